// File: doc/BRIEF.md
# Steered Byte-Lane Register Loader

This block sits on a narrow 8-bit write bus and fills a bank of eight byte-wide storage lanes that feed digital-to-analog converters. It uses just two bus addresses. A write to the steering address keeps a steering byte. A write to the data address is then offered to every lane at once. Only the lanes whose steering bit is low accept it. The steering byte stays in place, so a run of data writes lands in the same lanes until software writes a new steering byte.

Lanes 0 and 1 together form a 16-bit fine-tune word for the low-order converter. Each lane gives a one-cycle load strobe when it takes a byte. A full load is the steering byte plus six data bytes. A counter starts again at every steering write, and a done flag goes high once the sixth data byte has been written.

Top module: `steer_loader`

## Requirements
- R1: While reset is high, and in the cycle after it is released, steer_q is 8'hFF, every lane of lane_q is zero, lane_ld is zero and load_done is low.
- R2: A write (bus_wr high) to address 8'h70 puts bus_wdata into steer_q, visible in the cycle after the write edge. The same write changes no lane and raises no lane_ld bit.
- R3: A write to address 8'h71 stores bus_wdata into every lane i whose steer_q bit i is 0. Lane i sits at lane_q[8*i+7:8*i]. Lanes whose steering bit is 1 keep their value.
- R4: The steering value stays the same across any number of writes to 8'h71, so consecutive data bytes go to the same lanes.
- R5: When steer_q is 8'hFF, a write to 8'h71 changes no lane and raises no lane_ld bit.
- R6: lane_ld bit i is high only in the cycle right after a write edge at which lane i was loaded. It is low in every other cycle.
- R7: A bus cycle with bus_wr low, or with bus_wr high and any address other than 8'h70 or 8'h71, changes no output. It also does not advance the data-byte count.
- R8: fine_word always equals {lane 1, lane 0}.
- R9: load_done goes high in the cycle after the sixth write to 8'h71 since the last write to 8'h70 (or since reset). It stays high through further data writes, and it goes low in the cycle after the next write to 8'h70.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| steer_q | output | 8 | Held steering byte; bit i low enables lane i |
| lane_q | output | 64 | Eight storage lanes, lane i at bits 8*i+7:8*i |
| lane_ld | output | 8 | Per-lane one-cycle load strobe |
| fine_word | output | 16 | Fine-tune word formed from lanes 1 and 0 |
| load_done | output | 1 | High after six data bytes since the last steering byte |

## Verification
Every result comes from a single register stage. steer_q, the lanes, lane_ld and load_done therefore all show a write in the cycle that follows its clock edge, and lane_ld falls again one cycle after that. The bench drives the bus on the falling edge and releases the strobe on the next falling edge. It compares each output at that point, which is exactly one cycle after the write edge. It checks again one idle cycle later to confirm that the strobes have dropped and that nothing else has moved.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int BUS_DW = 8;
    localparam int BUS_AW = 8;
    localparam int LANES  = BUS_DW;

    typedef logic [BUS_DW-1:0] byte_t;
    typedef logic [BUS_AW-1:0] addr_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_STEER = 2'd1,
        OP_DATA  = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e op;
        byte_t   data;
    } bus_cmd_t;

    function automatic bus_op_e classify(input logic wr, input addr_t addr,
                                         input addr_t steer_a, input addr_t data_a);
        if (!wr)               return OP_IDLE;
        else if (addr == steer_a) return OP_STEER;
        else if (addr == data_a)  return OP_DATA;
        else                   return OP_IDLE;
    endfunction
endpackage

// File: rtl/steer_decode.sv
module steer_decode
    import steer_pkg::*;
#(
    parameter addr_t STEER_ADDR = 8'h70,
    parameter addr_t DATA_ADDR  = 8'h71
) (
    input  logic     wr,
    input  addr_t    addr,
    input  byte_t    wdata,
    output bus_cmd_t cmd
);
    always_comb begin
        cmd.op   = classify(wr, addr, STEER_ADDR, DATA_ADDR);
        cmd.data = wdata;
    end
endmodule

// File: rtl/steer_latch.sv
module steer_latch
    import steer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_cmd_t cmd,
    output byte_t    steer_n
);
    always_ff @(posedge clk) begin
        if (rst)
            steer_n <= '1;
        else if (cmd.op == OP_STEER)
            steer_n <= cmd.data;
    end
endmodule

// File: rtl/lane_bank.sv
module lane_bank
    import steer_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  bus_cmd_t                cmd,
    input  byte_t                   steer_n,
    output logic [LANES*BUS_DW-1:0] lanes,
    output logic [LANES-1:0]        loaded
);
    logic data_strobe_n;

    // Shared active-low strobe for the data address
    assign data_strobe_n = (cmd.op != OP_DATA);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic  gate_hit;
        byte_t store;

        // Coincidence of two low levels clocks this lane
        assign gate_hit = ~(data_strobe_n | steer_n[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                store     <= '0;
                loaded[i] <= 1'b0;
            end else begin
                loaded[i] <= gate_hit;
                if (gate_hit)
                    store <= cmd.data;
            end
        end

        assign lanes[i*BUS_DW +: BUS_DW] = store;
    end
endmodule

// File: rtl/load_counter.sv
module load_counter
    import steer_pkg::*;
#(
    parameter int DATA_BYTES = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_cmd_t cmd,
    output logic     done
);
    localparam int CW = $clog2(DATA_BYTES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DATA_BYTES);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (cmd.op == OP_STEER)
            count <= '0;
        else if (cmd.op == OP_DATA && count != LIMIT)
            count <= count + 1'b1;
    end

    assign done = (count == LIMIT);
endmodule

// File: rtl/steer_loader.sv
module steer_loader
    import steer_pkg::*;
#(
    parameter addr_t STEER_ADDR  = 8'h70,
    parameter addr_t DATA_ADDR   = 8'h71,
    parameter int    TOTAL_BYTES = 7,
    parameter int    FINE_LANES  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [BUS_AW-1:0]          bus_addr,
    input  logic [BUS_DW-1:0]          bus_wdata,
    output logic [BUS_DW-1:0]          steer_q,
    output logic [LANES*BUS_DW-1:0]    lane_q,
    output logic [LANES-1:0]           lane_ld,
    output logic [FINE_LANES*BUS_DW-1:0] fine_word,
    output logic                       load_done
);
    localparam int DATA_BYTES = TOTAL_BYTES - 1;

    bus_cmd_t cmd;

    steer_decode #(.STEER_ADDR(STEER_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .cmd(cmd)
    );

    steer_latch u_steer (
        .clk(clk), .rst(rst), .cmd(cmd), .steer_n(steer_q)
    );

    lane_bank u_bank (
        .clk(clk), .rst(rst), .cmd(cmd), .steer_n(steer_q),
        .lanes(lane_q), .loaded(lane_ld)
    );

    load_counter #(.DATA_BYTES(DATA_BYTES)) u_cnt (
        .clk(clk), .rst(rst), .cmd(cmd), .done(load_done)
    );

    assign fine_word = lane_q[FINE_LANES*BUS_DW-1:0];
endmodule

// File: rtl/steer_loader_chk.sv
module steer_loader_chk
    import steer_pkg::*;
#(
    parameter addr_t STEER_ADDR = 8'h70,
    parameter addr_t DATA_ADDR  = 8'h71
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_wr,
    input logic [BUS_AW-1:0]       bus_addr,
    input logic [BUS_DW-1:0]       bus_wdata,
    input logic [BUS_DW-1:0]       steer_q,
    input logic [LANES*BUS_DW-1:0] lane_q,
    input logic [LANES-1:0]        lane_ld,
    input logic                    load_done
);
    logic is_steer, is_data;
    assign is_steer = bus_wr && (bus_addr == STEER_ADDR);
    assign is_data  = bus_wr && (bus_addr == DATA_ADDR);

    a_r2_steer_capture: assert property (@(posedge clk) disable iff (rst)
        is_steer |=> (steer_q == $past(bus_wdata)));

    a_r2_steer_no_strobe: assert property (@(posedge clk) disable iff (rst)
        is_steer |=> (lane_ld == '0));

    a_r5_all_ones_blocks: assert property (@(posedge clk) disable iff (rst)
        (steer_q == '1) |=> (lane_ld == '0));

    a_r6_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
        (|lane_ld) |-> ((lane_ld & $past(steer_q)) == '0));

    a_r6_strobe_needs_data: assert property (@(posedge clk) disable iff (rst)
        (|lane_ld) |-> $past(is_data));

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !(is_steer || is_data) |=> ($stable(steer_q) && $stable(lane_q)
                                    && $stable(load_done) && lane_ld == '0));

    a_r9_steer_clears_done: assert property (@(posedge clk) disable iff (rst)
        is_steer |=> !load_done);
endmodule

bind steer_loader steer_loader_chk #(.STEER_ADDR(STEER_ADDR), .DATA_ADDR(DATA_ADDR)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .steer_q(steer_q), .lane_q(lane_q), .lane_ld(lane_ld), .load_done(load_done)
);

// File: tb/steer_loader_test.sv
module steer_loader_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  steer_q;
    logic [63:0] lane_q;
    logic [7:0]  lane_ld;
    logic [15:0] fine_word;
    logic        load_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] m_lane [8];
    logic [7:0] m_steer;
    int         m_count;
    logic [7:0] m_ld;

    always #2 clk = ~clk;

    steer_loader uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .steer_q(steer_q), .lane_q(lane_q),
        .lane_ld(lane_ld), .fine_word(fine_word), .load_done(load_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_lanes();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_lane[i];
        return v;
    endfunction

    task automatic check_all(input string req);
        chk({req, " steer"}, 64'(steer_q), 64'(m_steer));
        chk({req, " lanes"}, lane_q, model_lanes());
        chk({req, " R6 strobe"}, 64'(lane_ld), 64'(m_ld));
        chk({req, " R8 fine"}, 64'(fine_word), {48'h0, m_lane[1], m_lane[0]});
        chk({req, " R9 done"}, 64'(load_done), 64'(m_count >= 6));
    endtask

    // Bus cycle: drive at falling edge, release at next falling edge
    task automatic bus_cycle(input logic wr, input logic [7:0] a, input logic [7:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        m_ld = 8'h00;
        if (wr && a == 8'h70) begin
            m_steer = d;
            m_count = 0;
        end else if (wr && a == 8'h71) begin
            for (int i = 0; i < 8; i++)
                if (!m_steer[i]) begin
                    m_lane[i] = d;
                    m_ld[i] = 1'b1;
                end
            if (m_count < 6) m_count++;
        end
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        m_ld = 8'h00;
        check_all(req);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_lane[i] = 8'h00;
        m_steer = 8'hFF; m_count = 0; m_ld = 8'h00;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");

        // Sweep every steering value with one data byte each (R2, R3, R5)
        for (int s = 0; s < 256; s++) begin
            bus_cycle(1'b1, 8'h70, 8'(s));
            check_all("R2 steer write");
            bus_cycle(1'b1, 8'h71, 8'((s * 37 + 11) & 255));
            check_all(s == 255 ? "R5 all-ones data" : "R3 data write");
            idle_check("R6 strobe drop");
        end

        // Burst of data bytes under one steering value (R4, R9)
        bus_cycle(1'b1, 8'h70, 8'hF0);
        check_all("R9 cleared");
        for (int k = 0; k < 8; k++) begin
            bus_cycle(1'b1, 8'h71, 8'(8'hA0 + k));
            check_all("R4 R9 burst");
        end
        bus_cycle(1'b1, 8'h70, 8'hFC);
        check_all("R9 done falls");

        // Ignored cycles: other addresses and strobe low (R7)
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h70 && a != 8'h71) begin
                bus_cycle(1'b1, 8'(a), 8'(~a));
                check_all("R7 other address");
            end
        end
        bus_cycle(1'b0, 8'h71, 8'h5A);
        check_all("R7 strobe low data");
        bus_cycle(1'b0, 8'h70, 8'h00);
        check_all("R7 strobe low steer");

        // Count must not have moved: done exactly at sixth data byte (R7, R9)
        for (int k = 0; k < 6; k++) begin
            bus_cycle(1'b1, 8'h71, 8'(8'h31 * (k + 1)));
            check_all("R7 R9 count after ignored");
            if (k < 5) begin
                bus_cycle(1'b1, 8'h33, 8'hEE);
                check_all("R7 interleaved ignore");
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule